// File: doc/BRIEF.md
# USB Host Channel Transfer Tracker

This block holds the live state of one USB 2.0 host channel whose data moves by internal DMA. Software loads a control word and a buffer start address while the channel is idle. The control word holds four fields: a ping request, the first data PID, the number of packets expected, and the byte size of the transfer. Loading a control word with a nonzero packet count makes the channel busy.

While the channel is busy, the protocol engine reports each finished packet with a success flag and its byte count. The block then steps the packet count down, takes the bytes off the remaining size and moves the data PID to its next value. The AHB master pulses a beat strobe for each 32-bit bus beat, and the buffer pointer advances by one word on each beat. The transfer finishes when the packet count runs out, or when an IN packet arrives shorter than the maximum packet size. At that point a sticky interrupt flag is set and the channel returns to idle.

Top module: `usb_xfer_tracker`

## Requirements
- R1: After reset, the PID, packet count, remaining size, buffer pointer, interrupt, busy and ping outputs are all zero.
- R2: A control word written while idle loads its fields from these positions: ping at bit 31, PID at [30:29], packet count at [28:19], size at [18:0]. The channel becomes busy only when the loaded packet count is nonzero.
- R3: PID codes are DATA0=00, DATA1=01, DATA2=10 and 11 (MDATA, or SETUP on a control channel). A successful packet moves DATA0 to DATA1 and DATA1 to DATA0. On a control channel, SETUP moves to DATA1. Every other code moves to DATA0.
- R4: While busy, a successful packet lowers the packet count by one and lowers the remaining size by the packet's byte count. The remaining size stops at zero and never wraps.
- R5: A packet reported as failed leaves the PID, the packet count and the remaining size unchanged.
- R6: When a successful packet brings the packet count to zero, the interrupt flag is set and busy drops.
- R7: On an IN channel, a successful packet with fewer bytes than the maximum packet size ends the transfer: the interrupt is set and busy drops, even though packets remain.
- R8: The interrupt flag stays set until a clear pulse arrives. If a completion and a clear happen in the same cycle, the flag stays set.
- R9: A buffer address written while idle is loaded. Each beat strobe while busy adds 4 to the pointer. Beat strobes while idle leave the pointer unchanged.
- R10: While busy, control and address writes are ignored, and so are packet reports that arrive while idle. A disable pulse drops busy without setting the interrupt.
- R11: The ping request output equals the loaded ping bit while busy, and is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_word | input | 32 | Control word {ping, pid, count, size} |
| addr_wr | input | 1 | Buffer address write strobe |
| addr_word | input | 32 | Buffer start address |
| ch_dis | input | 1 | Disable pulse, aborts the transfer |
| int_clr | input | 1 | Write-1 clear of the interrupt flag |
| dir_in | input | 1 | 1 when the channel is an IN channel |
| ch_ctrl | input | 1 | 1 when the channel is a control channel |
| max_pkt | input | 11 | Maximum packet size in bytes |
| pkt_done | input | 1 | Packet finished pulse |
| pkt_ok | input | 1 | Packet succeeded (qualifies pkt_done) |
| pkt_bytes | input | 11 | Bytes in the finished packet |
| beat | input | 1 | One 32-bit AHB beat moved |
| cur_pid | output | 2 | PID of the next transaction |
| ping_req | output | 1 | Ping protocol requested |
| pkt_left | output | 10 | Packets still expected |
| size_left | output | 19 | Bytes still to move |
| dma_addr | output | 32 | Current buffer pointer |
| irq | output | 1 | Sticky completion interrupt |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest cases to reach need the transfer in a precise state when a particular event arrives. One is an early end on a short IN packet while packets still remain. Another is a completion that lands in the same cycle as an interrupt clear. A third is a size underflow, which only happens when the programmed size is smaller than the bytes actually moved. The bench reaches each of these by loading a control word chosen for that case: a short IN packet sent after one full packet, a one-packet transfer finished with the clear pulse held, and a 10-byte size finished by a 64-byte packet. It reaches the control-channel and DATA2 PID paths the same way, by loading those codes directly and sending one packet.

// File: rtl/usb_xfer_pkg.sv
// Package: shared PID encoding and the PID sequencing rule for the
// transfer tracker. Assumes 2-bit PID codes as listed in the brief.
package usb_xfer_pkg;

    typedef enum logic [1:0] {
        PID_DATA0 = 2'b00,
        PID_DATA1 = 2'b01,
        PID_DATA2 = 2'b10,
        PID_MSET  = 2'b11
    } pid_e;

    // Next PID after one successful packet.
    function automatic logic [1:0] pid_after(input logic [1:0] cur, input logic is_ctrl);
        logic [1:0] nxt;
        case (cur)
            PID_DATA0: nxt = PID_DATA1;
            PID_DATA1: nxt = PID_DATA0;
            PID_MSET:  nxt = is_ctrl ? PID_DATA1 : PID_DATA0;
            default:   nxt = PID_DATA0;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/xfer_pid_seq.sv
// Holds the data PID of the channel. Loads the software value on a
// control load, then steps it on each successful packet.
// Assumes load and adv are never high together (the top guarantees it).
module xfer_pid_seq
    import usb_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] load_pid,
    input  logic       adv,
    input  logic       is_ctrl,
    output logic [1:0] pid
);
    // PID register: load has priority, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)    pid <= PID_DATA0;
        else if (load) pid <= load_pid;
        else if (adv)  pid <= pid_after(pid, is_ctrl);
    end
endmodule

// File: rtl/xfer_count.sv
// Packet and byte counters of the transfer. The packet count steps down
// by one and the size by the packet's bytes; the size saturates at zero.
// Assumes adv only while the transfer is active with a nonzero count.
module xfer_count #(
    parameter int CNT_W   = 10,
    parameter int SIZE_W  = 19,
    parameter int BYTES_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_cnt,
    input  logic [SIZE_W-1:0]  load_size,
    input  logic               adv,
    input  logic [BYTES_W-1:0] bytes,
    output logic [CNT_W-1:0]   cnt,
    output logic [SIZE_W-1:0]  size,
    output logic               last
);
    localparam int WIDE = (SIZE_W > BYTES_W) ? SIZE_W : BYTES_W;

    logic [WIDE-1:0]   size_w, bytes_w;
    logic [SIZE_W-1:0] size_nxt;

    // Saturating byte subtraction.
    always_comb begin
        size_w   = WIDE'(size);
        bytes_w  = WIDE'(bytes);
        size_nxt = (bytes_w >= size_w) ? '0 : SIZE_W'(size_w - bytes_w);
    end

    assign last = (cnt == CNT_W'(1));

    // Counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            size <= '0;
        end else if (load) begin
            cnt  <= load_cnt;
            size <= load_size;
        end else if (adv) begin
            cnt  <= cnt - CNT_W'(1);
            size <= size_nxt;
        end
    end
endmodule

// File: rtl/xfer_dma_ptr.sv
// Buffer pointer: loaded by software, advanced by a fixed step per bus beat.
// Assumes the top gates beat with the active state.
module xfer_dma_ptr #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              beat,
    output logic [ADDR_W-1:0] addr
);
    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= load_addr;
        else if (beat) addr <= addr + ADDR_W'(STEP);
    end
endmodule

// File: rtl/usb_xfer_tracker.sv
// Per-channel transfer tracker for a DMA-driven USB host channel.
// Accepts programming only while idle, tracks PID/count/size/pointer
// while busy, and raises a sticky completion flag. Assumes pkt_done,
// beat, ch_dis and int_clr are single-cycle pulses.
module usb_xfer_tracker #(
    parameter int CNT_W      = 10,
    parameter int SIZE_W     = 19,
    parameter int BYTES_W    = 11,
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 4,
    localparam int CTL_W     = 3 + CNT_W + SIZE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [CTL_W-1:0]   ctl_word,
    input  logic               addr_wr,
    input  logic [ADDR_W-1:0]  addr_word,
    input  logic               ch_dis,
    input  logic               int_clr,
    input  logic               dir_in,
    input  logic               ch_ctrl,
    input  logic [BYTES_W-1:0] max_pkt,
    input  logic               pkt_done,
    input  logic               pkt_ok,
    input  logic [BYTES_W-1:0] pkt_bytes,
    input  logic               beat,
    output logic [1:0]         cur_pid,
    output logic               ping_req,
    output logic [CNT_W-1:0]   pkt_left,
    output logic [SIZE_W-1:0]  size_left,
    output logic [ADDR_W-1:0]  dma_addr,
    output logic               irq,
    output logic               busy
);
    localparam int PING_B = CTL_W - 1;
    localparam int PID_LO = CNT_W + SIZE_W;

    logic ctl_ld, addr_ld, adv, cnt_last, fin, ping_q;

    // Accept programming only while idle; step only on good packets while busy.
    assign ctl_ld  = ctl_wr & ~busy;
    assign addr_ld = addr_wr & ~busy;
    assign adv     = busy & pkt_done & pkt_ok;
    assign fin     = adv & (cnt_last | (dir_in & (pkt_bytes < max_pkt)));

    xfer_pid_seq u_pid (
        .clk(clk), .rst_n(rst_n), .load(ctl_ld),
        .load_pid(ctl_word[PID_LO +: 2]), .adv(adv),
        .is_ctrl(ch_ctrl), .pid(cur_pid)
    );

    xfer_count #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .BYTES_W(BYTES_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(ctl_ld),
        .load_cnt(ctl_word[SIZE_W +: CNT_W]), .load_size(ctl_word[SIZE_W-1:0]),
        .adv(adv), .bytes(pkt_bytes),
        .cnt(pkt_left), .size(size_left), .last(cnt_last)
    );

    xfer_dma_ptr #(.ADDR_W(ADDR_W), .STEP(BEAT_BYTES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(addr_ld), .load_addr(addr_word),
        .beat(beat & busy), .addr(dma_addr)
    );

    // Busy flag: disable and completion end the transfer, a load starts it.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy <= 1'b0;
        else if (ch_dis) busy <= 1'b0;
        else if (fin)    busy <= 1'b0;
        else if (ctl_ld) busy <= (ctl_word[SIZE_W +: CNT_W] != '0);
    end

    // Ping bit captured with the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)      ping_q <= 1'b0;
        else if (ctl_ld) ping_q <= ctl_word[PING_B];
    end

    assign ping_req = ping_q & busy;

    // Sticky completion flag; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (fin)     irq <= 1'b1;
        else if (int_clr) irq <= 1'b0;
    end
endmodule

// File: rtl/usb_xfer_tracker_chk.sv
// Checker for the transfer tracker, bound to every instance of the top.
module usb_xfer_tracker_chk #(
    parameter int CNT_W      = 10,
    parameter int SIZE_W     = 19,
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ch_dis,
    input logic              int_clr,
    input logic              addr_wr,
    input logic              pkt_done,
    input logic              pkt_ok,
    input logic              beat,
    input logic [1:0]        cur_pid,
    input logic              ping_req,
    input logic [CNT_W-1:0]  pkt_left,
    input logic [SIZE_W-1:0] size_left,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              irq,
    input logic              busy
);
    AST_PKT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        busy && pkt_done && pkt_ok && !ch_dis |=> pkt_left == CNT_W'($past(pkt_left) - CNT_W'(1))); // R4
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && pkt_done && !pkt_ok && !ch_dis |=> $stable(pkt_left) && $stable(size_left) && $stable(cur_pid)); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !busy); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !int_clr |=> irq); // R8
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && beat |=> dma_addr == ADDR_W'($past(dma_addr) + ADDR_W'(BEAT_BYTES))); // R9
    AST_IDLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && beat && !addr_wr |=> $stable(dma_addr)); // R9
    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !pkt_done && !ch_dis |=> $stable(pkt_left) && $stable(size_left) && $stable(cur_pid)); // R10
    AST_PING_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ping_req |-> busy); // R11
endmodule

bind usb_xfer_tracker usb_xfer_tracker_chk #(
    .CNT_W(CNT_W), .SIZE_W(SIZE_W), .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)
) u_chk (.*);

// File: tb/usb_xfer_tracker_tb.sv
module usb_xfer_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 0, addr_wr = 0, ch_dis = 0, int_clr = 0;
    logic [31:0] ctl_word = '0, addr_word = '0;
    logic        dir_in = 0, ch_ctrl = 0, pkt_done = 0, pkt_ok = 0, beat = 0;
    logic [10:0] max_pkt = 11'd64, pkt_bytes = '0;
    logic [1:0]  cur_pid;
    logic        ping_req, irq, busy;
    logic [9:0]  pkt_left;
    logic [18:0] size_left;
    logic [31:0] dma_addr;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    usb_xfer_tracker u_dut (.*);

    typedef struct packed {
        logic        ok;
        logic [10:0] bytes;
        logic [1:0]  pid;
        logic [9:0]  cnt;
        logic [18:0] size;
        logic        irq;
        logic        busy;
    } vec_t;

    // OUT transfer, 4 packets of 64 bytes, starting at DATA0.
    localparam vec_t VEC [5] = '{
        '{1'b1, 11'd64, 2'd1, 10'd3, 19'd192, 1'b0, 1'b1},
        '{1'b0, 11'd64, 2'd1, 10'd3, 19'd192, 1'b0, 1'b1},
        '{1'b1, 11'd64, 2'd0, 10'd2, 19'd128, 1'b0, 1'b1},
        '{1'b1, 11'd64, 2'd1, 10'd1, 19'd64,  1'b0, 1'b1},
        '{1'b1, 11'd64, 2'd0, 10'd0, 19'd0,   1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic p, input logic [1:0] pid, input logic [9:0] c, input logic [18:0] s);
        @(negedge clk); ctl_wr = 1; ctl_word = {p, pid, c, s};
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic wr_addr(input logic [31:0] a);
        @(negedge clk); addr_wr = 1; addr_word = a;
        @(negedge clk); addr_wr = 0;
    endtask

    task automatic pkt(input logic ok, input logic [10:0] n, input logic clr);
        @(negedge clk); pkt_done = 1; pkt_ok = ok; pkt_bytes = n; int_clr = clr;
        @(negedge clk); pkt_done = 0; pkt_ok = 0; int_clr = 0;
    endtask

    task automatic pulse_beat();
        @(negedge clk); beat = 1;
        @(negedge clk); beat = 0;
    endtask

    task automatic pulse_dis();
        @(negedge clk); ch_dis = 1;
        @(negedge clk); ch_dis = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 pid", cur_pid, 0);   chk("R1 cnt", pkt_left, 0);
        chk("R1 size", size_left, 0); chk("R1 addr", dma_addr, 0);
        chk("R1 irq", irq, 0);       chk("R1 busy", busy, 0);
        chk("R1 ping", ping_req, 0);

        wr_addr(32'h1000);
        chk("R9 addr load", dma_addr, 32'h1000);
        wr_ctl(0, 2'd0, 10'd4, 19'd256);
        chk("R2 busy", busy, 1); chk("R2 cnt", pkt_left, 4);
        chk("R2 size", size_left, 256); chk("R2 pid", cur_pid, 0);
        chk("R11 ping off", ping_req, 0);
        for (int i = 0; i < 3; i++) pulse_beat();
        chk("R9 beats", dma_addr, 32'h100C);
        wr_ctl(1, 2'd2, 10'd7, 19'd99);
        chk("R10 ctl ignored cnt", pkt_left, 4); chk("R10 ctl ignored pid", cur_pid, 0);
        wr_addr(32'h5000);
        chk("R10 addr ignored", dma_addr, 32'h100C);

        for (int i = 0; i < 5; i++) begin
            pkt(VEC[i].ok, VEC[i].bytes, 0);
            chk(VEC[i].ok ? "R3 pid" : "R5 pid", cur_pid, VEC[i].pid);
            chk(VEC[i].ok ? "R4 cnt" : "R5 cnt", pkt_left, VEC[i].cnt);
            chk(VEC[i].ok ? "R4 size" : "R5 size", size_left, VEC[i].size);
            chk("R6 irq", irq, VEC[i].irq);
            chk("R6 busy", busy, VEC[i].busy);
        end

        pulse_beat();
        chk("R9 idle beat", dma_addr, 32'h100C);
        pkt(1, 11'd64, 0);
        chk("R10 idle pkt", pkt_left, 0);
        chk("R8 irq held", irq, 1);
        @(negedge clk); int_clr = 1; @(negedge clk); int_clr = 0;
        chk("R8 irq cleared", irq, 0);

        dir_in = 1;
        wr_ctl(1, 2'd1, 10'd3, 19'd192);
        chk("R11 ping on", ping_req, 1);
        pkt(1, 11'd64, 0);
        chk("R3 in pid", cur_pid, 0); chk("R4 in cnt", pkt_left, 2);
        pkt(1, 11'd20, 0);
        chk("R7 short cnt", pkt_left, 1); chk("R7 short size", size_left, 108);
        chk("R7 short irq", irq, 1); chk("R7 short busy", busy, 0);
        chk("R11 ping idle", ping_req, 0);

        dir_in = 0;
        wr_ctl(0, 2'd0, 10'd1, 19'd64);
        pkt(1, 11'd64, 1);
        chk("R8 set beats clear", irq, 1); chk("R6 last cnt", pkt_left, 0);
        @(negedge clk); int_clr = 1; @(negedge clk); int_clr = 0;

        ch_ctrl = 1;
        wr_ctl(0, 2'd3, 10'd3, 19'd200);
        chk("R2 setup pid", cur_pid, 3);
        pkt(1, 11'd8, 0);
        chk("R3 setup->data1", cur_pid, 1); chk("R4 ctrl size", size_left, 192);
        pkt(1, 11'd64, 0);
        chk("R3 data1->data0", cur_pid, 0);
        pulse_dis();
        chk("R10 dis busy", busy, 0); chk("R10 dis no irq", irq, 0);

        ch_ctrl = 0;
        wr_ctl(0, 2'd3, 10'd2, 19'd10);
        pkt(1, 11'd64, 0);
        chk("R3 mdata->data0", cur_pid, 0); chk("R4 saturate", size_left, 0);
        chk("R4 sat cnt", pkt_left, 1);
        pulse_dis();
        wr_ctl(0, 2'd2, 10'd2, 19'd100);
        pkt(1, 11'd32, 0);
        chk("R3 data2->data0", cur_pid, 0);
        pulse_dis();
        wr_ctl(0, 2'd1, 10'd0, 19'd5);
        chk("R2 zero count idle", busy, 0); chk("R2 zero count size", size_left, 5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule